// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the byte-wide read path of a memory with a self-timed internal write cycle. It lets a host find out when that write has finished by reading the memory itself, so no separate ready pin is needed. While the write controller reports busy, a read does not return array contents. It returns a status byte instead. The top bit of that byte is the inverse of the top bit of the last byte written, and the next bit flips on every new read. Once busy drops, reads return true array data again.

The block also produces the output enable for the tri-state data pads. The memory array's read data arrives as a combinational input. The block registers both the enable and the data for one clock cycle. The bus control strobes are active low. A read is a cycle in which the select and read strobes are low and the write strobe is high.

Top module: `wr_status_reporter`

## Requirements
- R1: When chip_sel_n=0, rd_en_n=0 and wr_en_n=1 are sampled at a clock edge, bus_oe is 1 after that edge.
- R2: When chip_sel_n=1, rd_en_n=1 or wr_en_n=0 is sampled at an edge, bus_oe is 0 after that edge.
- R3: When busy=0 is sampled at an edge, bus_dout equals the arr_rdata sampled at that edge, on all bits.
- R4: When busy=1 is sampled, bus_dout bit 7 is the inverse of bit 7 of the last byte captured.
- R5: When busy=1 is sampled, bus_dout bits 5:0 equal bits 5:0 of the last byte captured.
- R6: A read start is rd_en_n sampled low after being sampled high, with chip_sel_n low. Each read start during busy inverts the toggle bit, which is bus_dout bit 6, and the new value shows on that same read. The first such read after reset shows 1.
- R7: The toggle bit holds its value in three cases: rd_en_n stays low, rd_en_n falls while chip_sel_n=1, or busy=0. Later busy reads continue the sequence from the held value.
- R8: The last-byte register loads wr_data on every edge where wr_capture=1. Reset clears it to 0.
- R9: While rst=1, bus_oe and bus_dout are 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_en_n | input | 1 | Read (output) strobe, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| busy | input | 1 | Self-timed write in progress |
| wr_capture | input | 1 | Strobe that captures the written byte |
| wr_data | input | DATA_W | Byte being written |
| arr_rdata | input | DATA_W | Combinational array read data |
| bus_dout | output | DATA_W | Registered data toward the pads |
| bus_oe | output | 1 | Registered tri-state enable for the pads |

## Verification
The bench builds the block at its default 8-bit width, with the polling bit at 7 and the toggle bit at 6. At this width every possible written byte can be captured and polled. The sweep therefore covers both values of the inverted top bit and every pattern on the low bits. It also runs all eight combinations of the three bus strobes. The toggle sequence is followed across the whole sweep. This includes held reads, reads with select high, and idle gaps between busy periods. Together these show that the toggle bit moves only on qualified read starts.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;

  // Decoded, active-high view of the bus strobes.
  typedef struct packed {
    logic sel;
    logic rd;
    logic wr;
  } bus_ctl_t;

  function automatic bus_ctl_t decode_ctl(input logic sel_n, input logic rd_n,
                                          input logic wr_n);
    bus_ctl_t c;
    c.sel = ~sel_n;
    c.rd  = ~rd_n;
    c.wr  = ~wr_n;
    return c;
  endfunction

endpackage

// File: rtl/wr_status_last_byte.sv
module wr_status_last_byte #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] last_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
    end else if (capture) begin
      last_q <= data_in;
    end
  end

endmodule

// File: rtl/wr_status_toggle.sv
module wr_status_toggle (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic sel,
  input  logic rd,
  output logic tog_next
);

  logic rd_prev;
  logic tog_q;
  logic advance;

  // Read start: strobe newly asserted while selected, counted only in busy.
  assign advance  = busy & sel & rd & ~rd_prev;
  assign tog_next = tog_q ^ advance;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      rd_prev <= rd;
      tog_q   <= tog_next;
    end
  end

endmodule

// File: rtl/wr_status_read_mux.sv
module wr_status_read_mux #(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = DATA_W - 1,
  parameter int TOG_BIT  = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              drive,
  input  logic              tog,
  input  logic [DATA_W-1:0] last_byte,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dout_q,
  output logic              oe_q
);

  logic [DATA_W-1:0] status_word;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign status_word[b] = ~last_byte[b];
    end else if (b == TOG_BIT) begin : g_tog
      assign status_word[b] = tog;
    end else begin : g_copy
      assign status_word[b] = last_byte[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      dout_q <= busy ? status_word : arr_rdata;
      oe_q   <= drive;
    end
  end

endmodule

// File: rtl/wr_status_reporter.sv
module wr_status_reporter #(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = DATA_W - 1,
  parameter int TOG_BIT  = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              rd_en_n,
  input  logic              wr_en_n,
  input  logic              busy,
  input  logic              wr_capture,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe
);
  import wr_status_pkg::*;

  bus_ctl_t          ctl;
  logic              drive;
  logic              tog_next;
  logic [DATA_W-1:0] last_byte;

  assign ctl   = decode_ctl(chip_sel_n, rd_en_n, wr_en_n);
  assign drive = ctl.sel & ctl.rd & ~ctl.wr;

  wr_status_last_byte #(.DATA_W(DATA_W)) u_last (
    .clk     (clk),
    .rst     (rst),
    .capture (wr_capture),
    .data_in (wr_data),
    .last_q  (last_byte)
  );

  wr_status_toggle u_tog (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .sel      (ctl.sel),
    .rd       (ctl.rd),
    .tog_next (tog_next)
  );

  wr_status_read_mux #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT)
  ) u_mux (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .drive     (drive),
    .tog       (tog_next),
    .last_byte (last_byte),
    .arr_rdata (arr_rdata),
    .dout_q    (bus_dout),
    .oe_q      (bus_oe)
  );

endmodule

// File: rtl/wr_status_checker.sv
module wr_status_checker #(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = DATA_W - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              chip_sel_n,
  input logic              rd_en_n,
  input logic              wr_en_n,
  input logic              busy,
  input logic              wr_capture,
  input logic [DATA_W-1:0] arr_rdata,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_oe
);

  a_r1_drive: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel_n && !rd_en_n && wr_en_n) |=> bus_oe);

  a_r2_hiz: assert property (@(posedge clk) disable iff (rst)
    (chip_sel_n || rd_en_n || !wr_en_n) |=> !bus_oe);

  a_r3_pass: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (bus_dout == $past(arr_rdata)));

  a_r4_poll_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(wr_capture))
      |=> (bus_dout[POLL_BIT] == $past(bus_dout[POLL_BIT])));

  a_r9_reset: assert property (@(posedge clk)
    rst |=> (!bus_oe && bus_dout == '0));

endmodule

bind wr_status_reporter wr_status_checker #(
  .DATA_W   (DATA_W),
  .POLL_BIT (POLL_BIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chip_sel_n (chip_sel_n),
  .rd_en_n    (rd_en_n),
  .wr_en_n    (wr_en_n),
  .busy       (busy),
  .wr_capture (wr_capture),
  .arr_rdata  (arr_rdata),
  .bus_dout   (bus_dout),
  .bus_oe     (bus_oe)
);

// File: tb/wr_status_reporter_test.sv
module wr_status_reporter_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chip_sel_n = 1'b1;
  logic       rd_en_n = 1'b1;
  logic       wr_en_n = 1'b1;
  logic       busy = 1'b0;
  logic       wr_capture = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] arr_rdata = '0;
  logic [7:0] bus_dout;
  logic       bus_oe;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  tog_model = 1'b0;
  logic [7:0] last_model = 8'h00;

  always #4 clk = ~clk;

  wr_status_reporter uut (
    .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .rd_en_n(rd_en_n),
    .wr_en_n(wr_en_n), .busy(busy), .wr_capture(wr_capture),
    .wr_data(wr_data), .arr_rdata(arr_rdata), .bus_dout(bus_dout),
    .bus_oe(bus_oe)
  );

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_exp(input logic [7:0] lb, input bit t);
    return {~lb[7], t, lb[5:0]};
  endfunction

  // Drive at the falling edge, sample 1 ns after the next rising edge.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic capture(input logic [7:0] v);
    @(negedge clk);
    wr_data = v; wr_capture = 1'b1;
    @(negedge clk);
    wr_capture = 1'b0;
    last_model = v;
  endtask

  // One full read: strobe low for one cycle, then released for one cycle.
  task automatic do_read(input string req, input logic [7:0] exp);
    @(negedge clk);
    chip_sel_n = 1'b0; rd_en_n = 1'b0; wr_en_n = 1'b1;
    step();
    check("R1", {7'b0, bus_oe}, 8'h01);
    check(req, bus_dout, exp);
    @(negedge clk);
    rd_en_n = 1'b1;
    step();
  endtask

  task automatic busy_read(input string req);
    tog_model = ~tog_model;
    do_read(req, status_exp(last_model, tog_model));
  endtask

  initial begin
    step(); step();
    check("R9", {7'b0, bus_oe}, 8'h00);
    check("R9", bus_dout, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    // R8: reset clears the last byte; R6: first busy read shows toggle 1.
    @(negedge clk);
    busy = 1'b1;
    busy_read("R8");
    check("R6", {7'b0, tog_model}, 8'h01);

    // R1 / R2: every strobe combination.
    @(negedge clk);
    busy = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      {chip_sel_n, rd_en_n, wr_en_n} = 3'(c);
      step();
      check(c == 1 ? "R1" : "R2", {7'b0, bus_oe}, (c == 1) ? 8'h01 : 8'h00);
    end
    @(negedge clk);
    {chip_sel_n, rd_en_n, wr_en_n} = 3'b111;

    // Sweep every written byte: R4/R5/R6 while busy, R3 after.
    for (int v = 0; v < 256; v++) begin
      capture(8'(v));
      @(negedge clk);
      busy = 1'b1;
      arr_rdata = 8'(v) ^ 8'h5A;
      busy_read("R4");
      busy_read("R5");
      @(negedge clk);
      busy = 1'b0;
      arr_rdata = 8'(v * 7 + 3);
      do_read("R3", 8'(v * 7 + 3));
    end

    // R7: held strobe does not advance the toggle bit.
    capture(8'h3C);
    @(negedge clk);
    busy = 1'b1;
    chip_sel_n = 1'b0; rd_en_n = 1'b0;
    tog_model = ~tog_model;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R7", bus_dout, status_exp(8'h3C, tog_model));
    end
    @(negedge clk);
    rd_en_n = 1'b1;
    // R7: strobe falling with select high does not advance.
    @(negedge clk);
    chip_sel_n = 1'b1;
    @(negedge clk);
    rd_en_n = 1'b0;
    @(negedge clk);
    rd_en_n = 1'b1;
    busy_read("R7");
    // R7: reads while idle do not advance; sequence resumes afterwards.
    @(negedge clk);
    busy = 1'b0;
    do_read("R3", arr_rdata);
    do_read("R3", arr_rdata);
    @(negedge clk);
    busy = 1'b1;
    busy_read("R7");

    // R8: capture during busy updates the polled byte.
    capture(8'hC5);
    busy_read("R8");
    step();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule